// File: doc/BRIEF.md
# Data Watchpoint Address Comparator

This block checks every data access a core makes against one programmed data watchpoint. Two things make up the programming. The first is a watch address. The second is a set of control fields: a per-byte select mask, a load/store qualifier, a range size, a link enable and a link index. Each access arrives with a one-cycle valid strobe and carries these fields:

- the virtual address;
- the size in bytes;
- a write flag;
- an atomic flag;
- a privilege-enable bit that the surrounding logic has already computed.

One clock cycle after the access, the block reports whether the watchpoint hit. It also reports whether the hit counts as a write or as a read.

There are two matching modes. In byte-select mode, every byte that a multi-byte access touches is compared against the bytes the select mask names. In range mode, the access is compared against a naturally aligned power-of-two region around the watch address. A watchpoint can be linked to a context breakpoint. In that case the block presents a query carrying the link index in the same cycle as the access. It then needs the returned context-match bit, as well as an address match, before it reports a hit.

Top module: `wp_cmp_top`

## Requirements
- R1: An access qualifies only under one of three conditions: it is a write and qualifier bit 1 (`cfgLsv[1]`) is set; it is a read and qualifier bit 0 (`cfgLsv[0]`) is set; or it is atomic, in which case the qualifier bits do not matter. An access that does not qualify never hits.
- R2: A byte-select mask (`cfgBas`) of zero never produces a hit, in byte-select mode or in range mode.
- R3: The watch address is word-aligned when bit 2 is 1 and bits 1:0 are 0. In that case only select bits 3:0 are used, bits 7:4 are ignored, and the range-mode floor is bit 2. For any other watch address, all 8 select bits are used and the floor is bit 3.
- R4: With a range size (`cfgMask`) of 0, select bit i names the byte at (watch address OR i). The access hits if any byte from its address up to its address + size − 1 equals a named byte.
- R5: With a nonzero range size greater than the floor, the access hits if any of its bytes agrees with the watch address in every bit from the top down to bit `cfgMask`.
- R6: With a nonzero range size no greater than the floor, the comparison instead runs from the top bit down to the floor bit.
- R7: When `cfgLinked` is 1, `linkQuery` is high together with `accValid`, and `linkQueryIdx` equals `cfgLinkNum`. A hit then also requires `linkMatch` to be 1 in the access cycle. When `cfgLinked` is 0, `linkQuery` stays low and `linkMatch` is ignored.
- R8: On a hit, `hitWrite` follows the write flag. The exception is an atomic access while `cfgLsv[0]` is set: that hit is reported as a read (`hitWrite` = 0). `hitWrite` is 0 whenever there is no hit.
- R9: Only access sizes of 1, 2, 4 and 8 can hit. Any other size gives no hit.
- R10: An access whose privilege-enable bit is 0 never hits.
- R11: `hitValid`, `hit` and `hitWrite` are registered. `hitValid` is high exactly in the cycle after `accValid`. After reset all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | ADDR_W | Watch address |
| cfgBas | input | 8 | Byte-select mask |
| cfgLsv | input | 2 | Qualifier: bit 1 write, bit 0 read |
| cfgMask | input | MASK_W | Range size as a bit index; 0 selects byte-select mode |
| cfgLinked | input | 1 | Require the linked breakpoint's context match |
| cfgLinkNum | input | LINK_W | Index of the linked breakpoint |
| accValid | input | 1 | Access strobe |
| accAddr | input | ADDR_W | Access virtual address |
| accSize | input | 4 | Access size in bytes |
| accWrite | input | 1 | Access is a write |
| accAtomic | input | 1 | Access is atomic |
| accPrivEn | input | 1 | Watchpoint enabled at the current privilege |
| linkQuery | output | 1 | Context query to the linked breakpoint |
| linkQueryIdx | output | LINK_W | Index of the queried breakpoint |
| linkMatch | input | 1 | Context-match answer from the linked breakpoint |
| hitValid | output | 1 | Result strobe, one cycle after the access |
| hit | output | 1 | Watchpoint hit |
| hitWrite | output | 1 | Hit counts as a write |

## Verification
The bench targets four corner cases, each with a typical wrong design in mind:

- **Accesses that straddle a watched byte.** These start below the byte or end just after it. A comparator that looks only at the first byte misses them.
- **Word-aligned watch addresses with the upper select bits set.** A design that ignores the alignment rule hits on bytes that are not named.
- **Range mode with small sizes and with a zero select mask.** Small sizes expose a missing floor clamp, because the compare then becomes too narrow. A zero select mask exposes a missing mask check, because the design then hits in range mode.
- **Atomic accesses under each qualifier setting, and linked watchpoints with the context answer low.** These catch a wrong read/write report and a link check that was skipped.

// File: rtl/wp_cmp_pkg.sv
package wp_cmp_pkg;
  localparam int LANE_MAX = 8;
  localparam int SHIFT_W  = 6;

  typedef struct packed {
    logic                rangeMode;
    logic [LANE_MAX-1:0] laneSel;
    logic [LANE_MAX-1:0] byteEn;
    logic [SHIFT_W-1:0]  loBit;
  } wpStrobe_t;
endpackage

// File: rtl/wp_cmp_datapath.sv
module wp_cmp_datapath
  import wp_cmp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] accAddr,
  input  wpStrobe_t         strobe,
  output logic              addrHit
);
  logic [ADDR_W-1:0]   byteAddr [LANE_MAX];
  logic [ADDR_W-1:0]   namedAddr [LANE_MAX];
  logic [LANE_MAX-1:0] rangeByteHit;
  logic [LANE_MAX-1:0] laneByteHit;
  logic [ADDR_W-1:0]   keepMask;

  assign keepMask = {ADDR_W{1'b1}} << strobe.loBit;

  for (genvar j = 0; j < LANE_MAX; j++) begin : gByte
    logic [LANE_MAX-1:0] perLane;
    assign byteAddr[j]  = accAddr + ADDR_W'(j);
    assign namedAddr[j] = cfgAddr | ADDR_W'(j);
    assign rangeByteHit[j] = strobe.byteEn[j] &&
                             (((byteAddr[j] ^ cfgAddr) & keepMask) == '0);
    for (genvar i = 0; i < LANE_MAX; i++) begin : gLane
      assign perLane[i] = strobe.laneSel[i] && (byteAddr[j] == namedAddr[i]);
    end
    assign laneByteHit[j] = strobe.byteEn[j] && (|perLane);
  end

  assign addrHit = strobe.rangeMode ? (|rangeByteHit) : (|laneByteHit);

  always_comb begin
    if (strobe.byteEn == '0) begin
      AST_NO_BYTES_NO_ADDR_HIT: assert (!addrHit); // R9
    end
  end
endmodule

// File: rtl/wp_cmp_ctrl.sv
module wp_cmp_ctrl
  import wp_cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 5,
  parameter int LINK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgBas,
  input  logic [1:0]        cfgLsv,
  input  logic [MASK_W-1:0] cfgMask,
  input  logic              cfgLinked,
  input  logic [LINK_W-1:0] cfgLinkNum,
  input  logic              accValid,
  input  logic [3:0]        accSize,
  input  logic              accWrite,
  input  logic              accAtomic,
  input  logic              accPrivEn,
  input  logic              linkMatch,
  input  logic              addrHit,
  output wpStrobe_t         strobe,
  output logic              linkQuery,
  output logic [LINK_W-1:0] linkQueryIdx,
  output logic              hitValid,
  output logic              hit,
  output logic              hitWrite
);
  localparam logic [SHIFT_W-1:0] FLOOR_WORD = SHIFT_W'(2);
  localparam logic [SHIFT_W-1:0] FLOOR_DBL  = SHIFT_W'(3);

  logic               wordAligned;
  logic               sizeOk;
  logic               accessQual;
  logic               hitNext;
  logic               writeNext;
  logic [SHIFT_W-1:0] floorBit;
  logic [SHIFT_W-1:0] maskWide;

  assign wordAligned = cfgAddr[2] && (cfgAddr[1:0] == 2'b00);
  assign sizeOk      = (accSize == 4'd1) || (accSize == 4'd2) ||
                       (accSize == 4'd4) || (accSize == 4'd8);
  assign floorBit    = wordAligned ? FLOOR_WORD : FLOOR_DBL;
  assign maskWide    = SHIFT_W'(cfgMask);

  always_comb begin
    strobe.rangeMode = (cfgMask != '0);
    strobe.laneSel   = wordAligned ? {4'b0000, cfgBas[3:0]} : cfgBas;
    strobe.loBit     = (maskWide > floorBit) ? maskWide : floorBit;
    for (int j = 0; j < LANE_MAX; j++) begin
      strobe.byteEn[j] = sizeOk && (j < int'(accSize));
    end
  end

  assign accessQual = (accWrite && cfgLsv[1]) || (!accWrite && cfgLsv[0]) || accAtomic;
  assign linkQuery    = accValid && cfgLinked;
  assign linkQueryIdx = cfgLinkNum;

  assign hitNext = accValid && accPrivEn && accessQual && (cfgBas != 8'h00) &&
                   addrHit && (!cfgLinked || linkMatch);
  assign writeNext = hitNext && accWrite && !(accAtomic && cfgLsv[0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hit      <= 1'b0;
      hitWrite <= 1'b0;
    end else begin
      hitValid <= accValid;
      hit      <= hitNext;
      hitWrite <= writeNext;
    end
  end

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> !hit); // R11
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> hitValid); // R11
  AST_BAS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && cfgBas == 8'h00) |=> !hit); // R2
  AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accPrivEn) |=> !hit); // R10
  AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && cfgLinked && !linkMatch) |=> !hit); // R7
  AST_UNQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accAtomic && ((accWrite && !cfgLsv[1]) || (!accWrite && !cfgLsv[0])))
    |=> !hit); // R1
  AST_ATOMIC_READ: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAtomic && cfgLsv[0]) |=> !hitWrite); // R8
  AST_WRITE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    hitWrite |-> hit); // R8
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !(accSize == 4'd1 || accSize == 4'd2 || accSize == 4'd4 || accSize == 4'd8))
    |=> !hit); // R9
endmodule

// File: rtl/wp_cmp_top.sv
module wp_cmp_top
  import wp_cmp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 5,
  parameter int LINK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgBas,
  input  logic [1:0]        cfgLsv,
  input  logic [MASK_W-1:0] cfgMask,
  input  logic              cfgLinked,
  input  logic [LINK_W-1:0] cfgLinkNum,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [3:0]        accSize,
  input  logic              accWrite,
  input  logic              accAtomic,
  input  logic              accPrivEn,
  output logic              linkQuery,
  output logic [LINK_W-1:0] linkQueryIdx,
  input  logic              linkMatch,
  output logic              hitValid,
  output logic              hit,
  output logic              hitWrite
);
  wpStrobe_t strobe;
  logic      addrHit;

  wp_cmp_ctrl #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .LINK_W(LINK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgBas(cfgBas), .cfgLsv(cfgLsv),
    .cfgMask(cfgMask), .cfgLinked(cfgLinked), .cfgLinkNum(cfgLinkNum),
    .accValid(accValid), .accSize(accSize), .accWrite(accWrite),
    .accAtomic(accAtomic), .accPrivEn(accPrivEn), .linkMatch(linkMatch),
    .addrHit(addrHit), .strobe(strobe), .linkQuery(linkQuery),
    .linkQueryIdx(linkQueryIdx), .hitValid(hitValid), .hit(hit), .hitWrite(hitWrite)
  );

  wp_cmp_datapath #(.ADDR_W(ADDR_W)) uDp (
    .cfgAddr(cfgAddr), .accAddr(accAddr), .strobe(strobe), .addrHit(addrHit)
  );
endmodule

// File: tb/tb_wp_cmp_top.sv
module tb_wp_cmp_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgAddr = '0;
  logic [7:0]  cfgBas = '0;
  logic [1:0]  cfgLsv = '0;
  logic [4:0]  cfgMask = '0;
  logic        cfgLinked = 1'b0;
  logic [3:0]  cfgLinkNum = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [3:0]  accSize = 4'd1;
  logic        accWrite = 1'b0;
  logic        accAtomic = 1'b0;
  logic        accPrivEn = 1'b1;
  logic        linkMatch = 1'b0;
  logic        linkQuery;
  logic [3:0]  linkQueryIdx;
  logic        hitValid, hit, hitWrite;

  int testsRun = 0;
  int testsFail = 0;

  typedef struct { logic expHit; logic expWr; string tag; } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  wp_cmp_top dut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgBas(cfgBas), .cfgLsv(cfgLsv),
    .cfgMask(cfgMask), .cfgLinked(cfgLinked), .cfgLinkNum(cfgLinkNum),
    .accValid(accValid), .accAddr(accAddr), .accSize(accSize), .accWrite(accWrite),
    .accAtomic(accAtomic), .accPrivEn(accPrivEn), .linkQuery(linkQuery),
    .linkQueryIdx(linkQueryIdx), .linkMatch(linkMatch), .hitValid(hitValid),
    .hit(hit), .hitWrite(hitWrite)
  );

  function automatic logic refHit();
    logic        ok;
    logic        wa;
    int          lanes, flo, lo;
    logic [31:0] b;
    if (!(accSize == 1 || accSize == 2 || accSize == 4 || accSize == 8)) return 1'b0;
    if (!accPrivEn) return 1'b0;
    ok = (accWrite && cfgLsv[1]) || (!accWrite && cfgLsv[0]) || accAtomic;
    if (!ok || cfgBas == 0) return 1'b0;
    if (cfgLinked && !linkMatch) return 1'b0;
    wa = (cfgAddr[2:0] == 3'b100);
    lanes = wa ? 4 : 8;
    flo = wa ? 2 : 3;
    for (int j = 0; j < int'(accSize); j++) begin
      b = accAddr + 32'(j);
      if (cfgMask == 0) begin
        for (int i = 0; i < lanes; i++)
          if (cfgBas[i] && b == (cfgAddr | 32'(i))) return 1'b1;
      end else begin
        lo = (int'(cfgMask) > flo) ? int'(cfgMask) : flo;
        if ((b >> lo) == (cfgAddr >> lo)) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [3:0] sz, input logic wr,
                        input logic at, input string tag);
    item_t it;
    @(posedge clk); #2;
    accValid = 1'b1; accAddr = a; accSize = sz; accWrite = wr; accAtomic = at;
    #1;
    check(linkQuery, cfgLinked, "R7", "linkQuery");
    if (cfgLinked) check(linkQueryIdx == cfgLinkNum, 1'b1, "R7", "linkQueryIdx");
    it.expHit = refHit();
    it.expWr  = it.expHit && wr && !(at && cfgLsv[0]);
    it.tag    = tag;
    sbq.push_back(it);
    @(posedge clk); #2;
    accValid = 1'b0;
  endtask

  task automatic expectHit(input logic [31:0] a, input logic [3:0] sz, input logic wr,
                           input logic at, input logic exp, input string tag);
    testsRun++;
    accAddr = a; accSize = sz; accWrite = wr; accAtomic = at;
    if (refHit() !== exp) begin
      testsFail++;
      $display("FAIL %s model: actual %0b expected %0b", tag, refHit(), exp);
    end
    access(a, sz, wr, at, tag);
  endtask

  task automatic setCfg(input logic [31:0] a, input logic [7:0] bas, input logic [1:0] lsv,
                        input logic [4:0] m);
    cfgAddr = a; cfgBas = bas; cfgLsv = lsv; cfgMask = m;
  endtask

  always @(negedge clk) begin
    if (rstN && hitValid) begin
      item_t it;
      if (sbq.size() == 0) begin
        testsRun++; testsFail++;
        $display("FAIL R11 unexpected hitValid: actual 1 expected 0");
      end else begin
        it = sbq.pop_front();
        check(hit, it.expHit, it.tag, "hit");
        check(hitWrite, it.expWr, "R8", "hitWrite");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++; testsFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #2;
    check(hitValid, 1'b0, "R11", "reset hitValid");
    check(hit, 1'b0, "R11", "reset hit");
    check(hitWrite, 1'b0, "R11", "reset hitWrite");
    rstN = 1'b1;

    // R4 byte-select, double-word aligned watch address
    setCfg(32'h1000, 8'h01, 2'b11, 5'd0);
    expectHit(32'h1000, 4'd1, 1'b0, 1'b0, 1'b1, "R4");
    expectHit(32'h0FFF, 4'd2, 1'b0, 1'b0, 1'b1, "R4");
    expectHit(32'h0FFF, 4'd1, 1'b0, 1'b0, 1'b0, "R4");
    expectHit(32'h1001, 4'd1, 1'b0, 1'b0, 1'b0, "R4");
    setCfg(32'h1000, 8'h80, 2'b11, 5'd0);
    expectHit(32'h1004, 4'd4, 1'b1, 1'b0, 1'b1, "R4");
    expectHit(32'h1000, 4'd8, 1'b0, 1'b0, 1'b1, "R4");
    expectHit(32'h1000, 4'd4, 1'b0, 1'b0, 1'b0, "R4");
    // R9 illegal sizes
    expectHit(32'h1005, 4'd3, 1'b0, 1'b0, 1'b0, "R9");
    expectHit(32'h1000, 4'd9, 1'b0, 1'b0, 1'b0, "R9");
    // R3 word-aligned: upper select bits ignored
    setCfg(32'h1004, 8'hF0, 2'b11, 5'd0);
    expectHit(32'h1004, 4'd8, 1'b0, 1'b0, 1'b0, "R3");
    setCfg(32'h1004, 8'h08, 2'b11, 5'd0);
    expectHit(32'h1006, 4'd2, 1'b0, 1'b0, 1'b1, "R3");
    // R2 zero select mask, both modes
    setCfg(32'h1000, 8'h00, 2'b11, 5'd0);
    expectHit(32'h1000, 4'd8, 1'b0, 1'b0, 1'b0, "R2");
    setCfg(32'h1000, 8'h00, 2'b11, 5'd8);
    expectHit(32'h1000, 4'd1, 1'b0, 1'b0, 1'b0, "R2");
    // R5 range mode above floor
    setCfg(32'h1234, 8'hFF, 2'b11, 5'd8);
    expectHit(32'h12FF, 4'd1, 1'b0, 1'b0, 1'b1, "R5");
    expectHit(32'h1300, 4'd1, 1'b0, 1'b0, 1'b0, "R5");
    expectHit(32'h11FF, 4'd2, 1'b0, 1'b0, 1'b1, "R5");
    expectHit(32'h11F8, 4'd8, 1'b0, 1'b0, 1'b0, "R5");
    // R6 range mode clamped to floor
    setCfg(32'h2000, 8'hFF, 2'b11, 5'd1);
    expectHit(32'h2007, 4'd1, 1'b0, 1'b0, 1'b1, "R6");
    expectHit(32'h2008, 4'd1, 1'b0, 1'b0, 1'b0, "R6");
    setCfg(32'h2004, 8'hFF, 2'b11, 5'd2);
    expectHit(32'h2007, 4'd1, 1'b0, 1'b0, 1'b1, "R6");
    expectHit(32'h2003, 4'd1, 1'b0, 1'b0, 1'b0, "R3");
    expectHit(32'h2008, 4'd1, 1'b0, 1'b0, 1'b0, "R6");
    // R1 qualification, R8 reported direction
    setCfg(32'h3000, 8'h01, 2'b10, 5'd0);
    expectHit(32'h3000, 4'd1, 1'b0, 1'b0, 1'b0, "R1");
    expectHit(32'h3000, 4'd1, 1'b1, 1'b0, 1'b1, "R1");
    expectHit(32'h3000, 4'd1, 1'b1, 1'b1, 1'b1, "R8");
    setCfg(32'h3000, 8'h01, 2'b01, 5'd0);
    expectHit(32'h3000, 4'd1, 1'b1, 1'b0, 1'b0, "R1");
    expectHit(32'h3000, 4'd1, 1'b1, 1'b1, 1'b1, "R8");
    setCfg(32'h3000, 8'h01, 2'b00, 5'd0);
    expectHit(32'h3000, 4'd1, 1'b1, 1'b1, 1'b1, "R1");
    expectHit(32'h3000, 4'd1, 1'b0, 1'b0, 1'b0, "R1");
    // R10 privilege gate
    setCfg(32'h3000, 8'h01, 2'b11, 5'd0);
    accPrivEn = 1'b0;
    expectHit(32'h3000, 4'd1, 1'b1, 1'b0, 1'b0, "R10");
    accPrivEn = 1'b1;
    // R7 linked watchpoint
    cfgLinked = 1'b1; cfgLinkNum = 4'd5; linkMatch = 1'b0;
    expectHit(32'h3000, 4'd1, 1'b0, 1'b0, 1'b0, "R7");
    linkMatch = 1'b1;
    expectHit(32'h3000, 4'd1, 1'b0, 1'b0, 1'b1, "R7");
    cfgLinked = 1'b0; linkMatch = 1'b0;
    expectHit(32'h3000, 4'd1, 1'b0, 1'b0, 1'b1, "R7");

    // mixed sweep against the bench model
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 96; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cfgAddr  = 32'h4000 | {28'h0, lfsr[3:0]} & 32'hFFFF_FFF4;
      cfgBas   = lfsr[15:8];
      cfgLsv   = lfsr[17:16];
      cfgMask  = lfsr[18] ? 5'd0 : {2'b00, lfsr[21:19]};
      accPrivEn = lfsr[22] | lfsr[23];
      access(32'h3FF8 + {27'h0, lfsr[28:24]}, 4'd1 << lfsr[30:29], lfsr[31], lfsr[4],
             "R4");
    end

    repeat (4) @(posedge clk);
    if (sbq.size() != 0) begin
      testsRun++; testsFail++;
      $display("FAIL R11 missing results: actual %0d expected 0", sbq.size());
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule